// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave for a Temperature Monitor

This block is an I2C target that runs on a fast system clock. It first passes SCL and SDA through synchronisers, then finds start, stop and clock edges in the synchronised signals. It holds a small register file that a bus master reaches through a pointer. The pointer keeps its value between transactions. The register file has four entries:

- a read-only temperature word, loaded from a sample port;
- an 8-bit configuration byte;
- a 9-bit lower (hysteresis) threshold;
- a 9-bit upper (trip) threshold.

The 9-bit values are two's complement in half-degree steps. On the bus they appear as a 16-bit word: the upper byte is sent first, and the temperature sits in the top nine bits.

A transaction has three phases. The master sends the address byte. When it writes, the next byte sets the pointer. Any further bytes are data for the selected register. A read that has no pointer byte returns the register chosen by the last pointer write.

- While a read is active, a new temperature sample is held back and is applied once the read ends.
- A one-cycle strobe marks each completed read, for use by the alarm-clear logic.
- If SDA stays low for longer than a programmable number of cycles, the interface returns to idle and releases the line.

Top module: `i2c_ptr_regs`

## Requirements
- R1: The target answers only to the 7-bit address `1001` followed by `strap[2:0]`, with `strap[2]` as the most significant. When the address matches, it pulls SDA low in the acknowledge slot. Any other address gets no acknowledge and no further response until the next start.
- R2: In a write, the first byte after the address is the pointer, and its two low bits select the register: 0 temperature, 1 configuration, 2 lower threshold, 3 upper threshold. The pointer is 0 after reset.
- R3: The pointer holds its last written value. A read without a pointer byte returns that register, and so does a read that follows a pointer write and a repeated start.
- R4: In a configuration write, the first and second data bytes are both stored in `cfg_q`, so the second byte replaces the first. Later bytes are acknowledged and discarded. `cfg_q` is 0 after reset.
- R5: In a threshold write, the first data byte becomes value bits 8:1 and value bit 0 is cleared. Bit 7 of a second byte sets value bit 0. Any third or later byte is acknowledged and discarded. After reset, the lower threshold is 150 and the upper threshold is 160 (75.0 and 80.0 degrees).
- R6: The temperature register cannot be written: data bytes sent to pointer 0 are acknowledged but do not change what is read back.
- R7: A 9-bit value v is read as two bytes, each sent MSB first. The first byte is v[8:1]. The second byte is {v[0], 7'b0}.
- R8: After the master acknowledges a data byte, the next byte follows. For a 16-bit register, the byte after the second is the upper byte again. The configuration register repeats its byte. A NACK from the master ends the read and releases SDA.
- R9: A temperature sample that arrives during a read does not change the bytes of that read. The sample takes effect as soon as the read ends.
- R10: `rd_strobe` is high for exactly one cycle each time the master NACKs a read byte. It never pulses during a write.
- R11: If the SDA line stays low for TO_CYCLES consecutive clocks, the target returns to idle and stops driving SDA. Correct transfers still work after the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap | input | 3 | Low three address bits |
| smp_vld | input | 1 | One-cycle qualifier for a new temperature sample |
| smp_val | input | 9 | Temperature sample, two's complement, 0.5 degree per LSB |
| cfg_q | output | 8 | Configuration register |
| thyst_q | output | 9 | Lower threshold value |
| tos_q | output | 9 | Upper threshold value |
| rd_strobe | output | 1 | One-cycle pulse on a completed register read |

## Verification
Three kinds of address byte are tried: a matching one, one that differs only in the strap bits, and one that differs only in the fixed prefix. Together they show that both parts of the address are compared. Threshold writes use one, two and three data bytes, and the configuration register gets two. These show the difference between keeping the upper byte, merging bit 7 of a second byte, and discarding later bytes. Reads are made with a fresh pointer, with a sticky pointer, across a repeated start, past the second byte, and with a sample arriving between the two bytes. These separate pointer handling, byte order, wrap-around and the sample hold. A stalled read whose data bit is low leaves SDA pinned, which checks that the timeout releases the line.

// File: rtl/i2c_ptr_regs.sv
module i2c_ptr_regs #(
  parameter int          TO_CYCLES = 2_500_000,
  parameter logic [8:0]  THYST_RST = 9'd150,
  parameter logic [8:0]  TOS_RST   = 9'd160,
  localparam int         TOW       = $clog2(TO_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       smp_vld,
  input  logic [8:0] smp_val,
  output logic [7:0] cfg_q,
  output logic [8:0] thyst_q,
  output logic [8:0] tos_q,
  output logic       rd_strobe
);
  localparam logic [3:0] S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2,
                         S_PTR  = 4'd3, S_PACK = 4'd4, S_WD   = 4'd5,
                         S_WACK = 4'd6, S_RD   = 4'd7, S_RACK = 4'd8;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [3:0] st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [1:0] ptr;
  logic [1:0] widx;
  logic       bidx, rw, rd_act;
  logic [8:0] temp_r, pend;
  logic       pend_v;
  logic [TOW-1:0] to_cnt;
  logic [8:0] src;
  logic [7:0] tx_byte;

  wire scl      = scl_sy[1];
  wire sda      = sda_sy[1];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire to_hit   = (to_cnt == TOW'(TO_CYCLES - 1));
  wire byte_in  = scl_fall && (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl;
      sda_d  <= sda;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      to_cnt <= '0;
    else if (sda)    to_cnt <= '0;
    else if (!to_hit) to_cnt <= to_cnt + 1'b1;

  always_comb begin
    case (ptr)
      2'd2:    src = thyst_q;
      2'd3:    src = tos_q;
      default: src = temp_r;
    endcase
    if (ptr == 2'd1)  tx_byte = cfg_q;
    else if (bidx)    tx_byte = {src[0], 7'b0};
    else              tx_byte = src[8:1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      temp_r <= '0; pend <= '0; pend_v <= 1'b0;
    end else if (smp_vld && !rd_act) begin
      temp_r <= smp_val; pend_v <= 1'b0;
    end else if (smp_vld) begin
      pend <= smp_val; pend_v <= 1'b1;
    end else if (!rd_act && pend_v) begin
      temp_r <= pend; pend_v <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ptr <= '0; widx <= '0;
      bidx <= 1'b0; rw <= 1'b0; rd_act <= 1'b0; sda_oe <= 1'b0;
      rd_strobe <= 1'b0; cfg_q <= '0; thyst_q <= THYST_RST; tos_q <= TOS_RST;
    end else begin
      rd_strobe <= 1'b0;
      if (to_hit || stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; rd_act <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; rd_act <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_PTR, S_WD: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 1'b1;
            end else if (byte_in) begin
              sda_oe <= 1'b1;
              case (st)
                S_ADDR: begin
                  if (sh[7:1] == {4'b1001, strap}) begin
                    st <= S_AACK; rw <= sh[0]; bidx <= 1'b0;
                  end else begin
                    st <= S_IDLE; sda_oe <= 1'b0;
                  end
                end
                S_PTR: begin
                  ptr <= sh[1:0]; widx <= '0; st <= S_PACK;
                end
                default: begin
                  st <= S_WACK;
                  if (widx != 2'd2) begin
                    widx <= widx + 1'b1;
                    case (ptr)
                      2'd1: cfg_q <= sh;
                      2'd2: if (widx == 2'd0) thyst_q <= {sh, 1'b0};
                            else              thyst_q[0] <= sh[7];
                      2'd3: if (widx == 2'd0) tos_q <= {sh, 1'b0};
                            else              tos_q[0] <= sh[7];
                      default: ;
                    endcase
                  end
                end
              endcase
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= S_RD; rd_act <= 1'b1; sda_oe <= ~tx_byte[7];
            end else begin
              st <= S_PTR; sda_oe <= 1'b0;
            end
          end
          S_PACK, S_WACK: if (scl_fall) begin
            st <= S_WD; cnt <= '0; sda_oe <= 1'b0;
          end
          S_RD: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_RACK;
              end else begin
                sda_oe <= ~tx_byte[3'd7 - cnt[2:0]];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda) begin
                st <= S_IDLE; rd_act <= 1'b0; rd_strobe <= 1'b1;
              end else begin
                bidx <= ~bidx;
              end
            end else if (scl_fall) begin
              st <= S_RD; cnt <= '0; sda_oe <= ~tx_byte[7];
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_ptr_regs_chk.sv
module i2c_ptr_regs_chk #(
  parameter int TO_CYCLES = 2_500_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       rd_strobe,
  input logic       rd_act,
  input logic [8:0] temp_r,
  input logic [3:0] st,
  input logic [7:0] cfg_q,
  input logic [8:0] thyst_q,
  input logic [8:0] tos_q
);
  logic [31:0] oe_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      oe_run <= '0;
    else if (sda_oe) oe_run <= oe_run + 1;
    else             oe_run <= '0;

  a_r10_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  a_r10_strobe_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> !rd_act);

  a_r5_limits_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tos_q) || !$stable(thyst_q)) |-> ($past(st) == 4'd5));

  a_r4_cfg_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> ($past(st) == 4'd5));

  a_r9_temp_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> $stable(temp_r));

  a_r11_oe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    oe_run < 32'(TO_CYCLES) + 32'd8);
endmodule

bind i2c_ptr_regs i2c_ptr_regs_chk #(.TO_CYCLES(TO_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .rd_strobe(rd_strobe),
  .rd_act(rd_act), .temp_r(temp_r), .st(st), .cfg_q(cfg_q),
  .thyst_q(thyst_q), .tos_q(tos_q)
);

// File: tb/i2c_ptr_regs_tb_top.sv
module i2c_ptr_regs_tb_top;
  localparam int TO = 3000;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic smp_vld = 1'b0;
  logic [8:0] smp_val = '0;
  logic sda_oe, rd_strobe;
  logic [7:0] cfg_q;
  logic [8:0] thyst_q, tos_q;
  wire sda_ln = sda_m & ~sda_oe;

  int vectors = 0, fails = 0, strobes = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_ptr_regs #(.TO_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe),
    .strap(strap), .smp_vld(smp_vld), .smp_val(smp_val), .cfg_q(cfg_q),
    .thyst_q(thyst_q), .tos_q(tos_q), .rd_strobe(rd_strobe)
  );

  always @(posedge clk) if (rd_strobe) strobes <= strobes + 1;

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic b_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic b_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask
  task automatic b_bit(input logic b, output logic r);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(Q); r = sda_ln; wt(Q); scl_m = 1'b0; wt(Q);
  endtask
  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) b_bit(b[i], r);
    b_bit(1'b1, r);
    ack = ~r;
  endtask
  task automatic rd_byte(input logic last, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin b_bit(1'b1, r); v[i] = r; end
    b_bit(last, r);
  endtask

  function automatic logic [7:0] adr(input logic rd);
    return {4'b1001, strap, rd};
  endfunction

  task automatic t_reset();
    chk("R2 reset sda_oe", 16'(sda_oe), 16'h0);
    chk("R4 reset cfg", 16'(cfg_q), 16'h00);
    chk("R5 reset thyst", 16'(thyst_q), 16'd150);
    chk("R5 reset tos", 16'(tos_q), 16'd160);
    chk("R10 reset strobe", 16'(rd_strobe), 16'h0);
  endtask

  task automatic t_address();
    logic a;
    b_start(); wr_byte({4'b1001, 3'b010, 1'b0}, a); b_stop();
    chk("R1 wrong strap nack", 16'(a), 16'h0);
    b_start(); wr_byte({4'b1000, strap, 1'b0}, a); b_stop();
    chk("R1 wrong prefix nack", 16'(a), 16'h0);
    b_start(); wr_byte(adr(1'b0), a); b_stop();
    chk("R1 match ack", 16'(a), 16'h1);
  endtask

  task automatic t_read_temp();
    logic a; logic [7:0] b0, b1, b2; int s0;
    s0 = strobes;
    b_start(); wr_byte(adr(1'b1), a);
    rd_byte(1'b0, b0); rd_byte(1'b0, b1); rd_byte(1'b1, b2); b_stop();
    chk("R2 default pointer temp hi", 16'(b0), 16'h19);
    chk("R7 temp lo byte", 16'(b1), 16'h00);
    chk("R8 wrap to hi byte", 16'(b2), 16'h19);
    chk("R10 one strobe per read", 16'(strobes - s0), 16'd1);
  endtask

  task automatic t_cfg_write();
    logic a0, a1, a2, a3; int s0;
    s0 = strobes;
    b_start(); wr_byte(adr(1'b0), a0); wr_byte(8'h01, a1);
    wr_byte(8'h1A, a2); wr_byte(8'h06, a3); b_stop();
    chk("R4 second byte replaces first", 16'(cfg_q), 16'h06);
    chk("R4 bytes acked", 16'({a0, a1, a2, a3}), 16'hF);
    chk("R10 no strobe on write", 16'(strobes - s0), 16'd0);
  endtask

  task automatic t_lim_write();
    logic a; logic a3;
    b_start(); wr_byte(adr(1'b0), a); wr_byte(8'h02, a); wr_byte(8'h40, a); b_stop();
    chk("R5 single byte to upper", 16'(thyst_q), 16'h080);
    b_start(); wr_byte(adr(1'b0), a); wr_byte(8'h03, a);
    wr_byte(8'h55, a); wr_byte(8'h80, a); wr_byte(8'h00, a3); b_stop();
    chk("R5 two bytes merged, third ignored", 16'(tos_q), 16'h0AB);
    chk("R5 third byte acked", 16'(a3), 16'h1);
  endtask

  task automatic t_sticky();
    logic a; logic [7:0] b0, b1;
    b_start(); wr_byte(adr(1'b1), a); rd_byte(1'b0, b0); rd_byte(1'b1, b1); b_stop();
    chk("R3 sticky pointer hi", 16'(b0), 16'h55);
    chk("R7 limit lo byte", 16'(b1), 16'h80);
    b_start(); wr_byte(adr(1'b0), a); wr_byte(8'h01, a);
    b_start(); wr_byte(adr(1'b1), a); rd_byte(1'b0, b0); rd_byte(1'b1, b1); b_stop();
    chk("R3 repeated start cfg read", 16'(b0), 16'h06);
    chk("R8 cfg repeats", 16'(b1), 16'h06);
  endtask

  task automatic t_temp_ro();
    logic a, a2; logic [7:0] b0, b1;
    b_start(); wr_byte(adr(1'b0), a); wr_byte(8'h00, a);
    wr_byte(8'hAA, a2); wr_byte(8'hAA, a); b_stop();
    chk("R6 write to temp acked", 16'(a2), 16'h1);
    b_start(); wr_byte(adr(1'b1), a); rd_byte(1'b0, b0); rd_byte(1'b1, b1); b_stop();
    chk("R6 temp unchanged", 16'({b0, b1}), 16'h1900);
  endtask

  task automatic t_freeze();
    logic a; logic [7:0] b0, b1;
    b_start(); wr_byte(adr(1'b1), a); rd_byte(1'b0, b0);
    smp_val = 9'h033; smp_vld = 1'b1; wt(1); smp_vld = 1'b0;
    rd_byte(1'b1, b1); b_stop();
    chk("R9 read not torn", 16'({b0, b1}), 16'h1900);
    b_start(); wr_byte(adr(1'b1), a); rd_byte(1'b0, b0); rd_byte(1'b1, b1); b_stop();
    chk("R9 held sample applied", 16'({b0, b1}), 16'h1980);
  endtask

  task automatic t_timeout();
    logic a; logic [7:0] b0, b1;
    smp_val = 9'h000; smp_vld = 1'b1; wt(1); smp_vld = 1'b0;
    b_start(); wr_byte(adr(1'b1), a);
    wt(Q);
    chk("R11 stalled read holds SDA", 16'(sda_oe), 16'h1);
    wt(TO + 20);
    chk("R11 SDA released after timeout", 16'(sda_oe), 16'h0);
    b_stop();
    smp_val = 9'h1CE; smp_vld = 1'b1; wt(1); smp_vld = 1'b0;
    b_start(); wr_byte(adr(1'b1), a); rd_byte(1'b0, b0); rd_byte(1'b1, b1); b_stop();
    chk("R11 bus usable after recovery", 16'({b0, b1}), 16'hE700);
  endtask

  initial begin
    wt(4); rst_n = 1'b1; wt(4);
    t_reset();
    smp_val = 9'h032; smp_vld = 1'b1; wt(1); smp_vld = 1'b0; wt(2);
    t_address();
    t_read_temp();
    t_cfg_write();
    t_lim_write();
    t_sticky();
    t_temp_ro();
    t_freeze();
    t_timeout();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule